// File: doc/BRIEF.md
# CAN Controller Reset and Mode Sequencer

This block owns the operating mode of a CAN controller. After a hardware reset, or whenever software sets the soft-reset control bit, it holds the controller in configuration mode. In that mode software may program bit timing and mailboxes. The block also raises a reset status flag and a reset interrupt flag. Software then clears the soft-reset bit. The block now waits for a run of consecutive recessive bits on the bus, which shows the bus is idle. It then lets a fixed settling delay pass before it clears the status flag and joins bus activity.

Once joined, the block moves between idle, transmitting and receiving. A non-zero pending-transmit vector starts a transmission and emits a one-cycle start pulse. A strobed dominant bit while idle starts a reception. A lost arbitration turns the transmitter into a receiver. A frame-done indication returns the block to idle, where pending requests are looked at again. Bit timing, framing, CRC and stuffing are not part of this block; it only sequences modes.

Top module: `can_mode_seq`

## Requirements
- R1: During and after hardware reset, the soft-reset bit reads as set: mode is configuration, the status flag is 1, the reset interrupt flag is 1 and the start pulse is 0.
- R2: A write of 1 to the soft-reset bit puts the block in configuration mode with the status flag at 1 on the next cycle, from any mode. The reset interrupt flag is set only when the bit goes from 0 to 1.
- R3: The reset interrupt flag stays set until the clear input is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R4: A write of 0 to the soft-reset bit moves configuration mode to joining. Joining needs JOIN_BITS (default 11) consecutive strobed recessive (1) bits. A strobed dominant (0) bit restarts the count from zero. Cycles without the bit strobe are ignored.
- R5: The status flag drops to 0 and the mode turns to idle exactly SETTLE (default 25) clock cycles after the edge that sampled the last recessive bit of the run.
- R6: In idle, a non-zero pending-transmit vector moves the block to transmitting on the next cycle. The start pulse is high for exactly that one cycle. Pending requests take priority over a reception start.
- R7: In idle with nothing pending, a strobed dominant bit moves the block to receiving. An unstrobed dominant bit does nothing.
- R8: In transmitting, arbitration loss moves the block to receiving on the next cycle. This takes priority over frame done.
- R9: Frame done in transmitting or receiving returns the block to idle. Requests still pending then start a new transmission one cycle later.
- R10: The mode port is 3 bits wide and encoded as configuration=0, joining=1, idle=2, transmitting=3, receiving=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| swrst_we | input | 1 | Write strobe for the soft-reset control bit |
| swrst_wdata | input | 1 | Value written to the soft-reset control bit |
| irq_clr | input | 1 | Pulse that clears the reset interrupt flag |
| rx_bit | input | 1 | Sampled bus level (1 = recessive) |
| bit_stb | input | 1 | One-cycle strobe marking a valid bus sample |
| tx_pend | input | TXN | Pending-transmit request vector |
| arb_lost | input | 1 | Arbitration lost during transmission |
| frame_done | input | 1 | Current frame completed |
| cfg_status | output | 1 | Reset/configuration status flag |
| rst_irq | output | 1 | Reset interrupt flag |
| mode | output | 3 | Current mode (encoding in R10) |
| tx_start | output | 1 | One-cycle start-transmit pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- a soft-reset write always lands in configuration mode;
- the interrupt flag rises on entry;
- the recessive count never passes its limit;
- the start pulse only follows an idle-to-transmit step;
- arbitration loss always yields a receiver;
- a cleared status flag never coexists with configuration or joining.

The bench scenarios cover what needs whole sequences:
- sweeps of where a dominant bit breaks the recessive run;
- the exact 25-cycle settling edge;
- every pending-vector value;
- the interrupt set-versus-clear race.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_CFG  = 3'd0,
    MODE_JOIN = 3'd1,
    MODE_IDLE = 3'd2,
    MODE_TX   = 3'd3,
    MODE_RX   = 3'd4
  } mode_e;
endpackage

// File: rtl/can_rst_sync.sv
module can_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/can_join_detect.sv
module can_join_detect #(
  parameter int JOIN_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic bus_bit,
  output logic join_ok
);
  localparam int CW = $clog2(JOIN_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(JOIN_BITS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else if (stb)           cnt_d = bus_bit ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign join_ok = en && (cnt_q == LIMIT);

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r4_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && !bus_bit && cnt_q != LIMIT) |=> (cnt_q == '0));
endmodule

// File: rtl/can_settle_timer.sv
module can_settle_timer #(
  parameter int SETTLE = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [TW-1:0] LAST = TW'(SETTLE - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);

  a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  force_cfg,
  input  logic  join_done,
  input  logic  tx_req,
  input  logic  rx_bit,
  input  logic  bit_stb,
  input  logic  arb_lost,
  input  logic  frame_done,
  output mode_e mode_q,
  output logic  status_q,
  output logic  tx_start_q
);
  mode_e mode_d;
  logic  status_d, tx_start_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_CFG:  mode_d = MODE_JOIN;
      MODE_JOIN: if (join_done) mode_d = MODE_IDLE;
      MODE_IDLE: begin
        if (tx_req)                 mode_d = MODE_TX;
        else if (bit_stb && !rx_bit) mode_d = MODE_RX;
      end
      MODE_TX: begin
        if (arb_lost)        mode_d = MODE_RX;
        else if (frame_done) mode_d = MODE_IDLE;
      end
      MODE_RX:   if (frame_done) mode_d = MODE_IDLE;
      default:   mode_d = MODE_CFG;
    endcase
    if (force_cfg) mode_d = MODE_CFG;

    status_d = status_q;
    if (force_cfg)      status_d = 1'b1;
    else if (join_done) status_d = 1'b0;

    tx_start_d = (mode_q == MODE_IDLE) && (mode_d == MODE_TX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_CFG;
      status_q   <= 1'b1;
      tx_start_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      status_q   <= status_d;
      tx_start_q <= tx_start_d;
    end
  end

  a_r6_start_follows_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_q |-> (mode_q == MODE_TX && $past(mode_q) == MODE_IDLE));
  a_r8_arb_loss_receives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TX && arb_lost && !force_cfg) |=> (mode_q == MODE_RX));
  a_r5_status_low_joined: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q |-> (mode_q != MODE_CFG && mode_q != MODE_JOIN));
  a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q inside {MODE_CFG, MODE_JOIN, MODE_IDLE, MODE_TX, MODE_RX});
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int TXN       = 4,
  parameter int JOIN_BITS = 11,
  parameter int SETTLE    = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swrst_we,
  input  logic           swrst_wdata,
  input  logic           irq_clr,
  input  logic           rx_bit,
  input  logic           bit_stb,
  input  logic [TXN-1:0] tx_pend,
  input  logic           arb_lost,
  input  logic           frame_done,
  output logic           cfg_status,
  output logic           rst_irq,
  output logic [2:0]     mode,
  output logic           tx_start
);
  logic  srst_n;
  logic  swrst_q, swrst_d;
  logic  irq_q, irq_d;
  logic  in_join, join_ok, settle_done;
  mode_e mode_q;

  can_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    swrst_d = swrst_we ? swrst_wdata : swrst_q;
    irq_d   = irq_q;
    if (swrst_d && !swrst_q) irq_d = 1'b1;
    else if (irq_clr)        irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      swrst_q <= 1'b1;
      irq_q   <= 1'b1;
    end else begin
      swrst_q <= swrst_d;
      irq_q   <= irq_d;
    end
  end

  assign in_join = (mode_q == MODE_JOIN);

  can_join_detect #(.JOIN_BITS(JOIN_BITS)) u_join (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (in_join),
    .stb     (bit_stb),
    .bus_bit (rx_bit),
    .join_ok (join_ok)
  );

  can_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk  (clk),
    .rst_n(srst_n),
    .run  (join_ok),
    .done (settle_done)
  );

  can_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .force_cfg  (swrst_d),
    .join_done  (settle_done),
    .tx_req     (|tx_pend),
    .rx_bit     (rx_bit),
    .bit_stb    (bit_stb),
    .arb_lost   (arb_lost),
    .frame_done (frame_done),
    .mode_q     (mode_q),
    .status_q   (cfg_status),
    .tx_start_q (tx_start)
  );

  assign mode    = mode_q;
  assign rst_irq = irq_q;

  a_r2_swrst_forces_cfg: assert property (@(posedge clk) disable iff (!srst_n)
    (swrst_we && swrst_wdata) |=> (mode == 3'd0 && cfg_status));
  a_r2_irq_on_entry: assert property (@(posedge clk) disable iff (!srst_n)
    (swrst_we && swrst_wdata && !swrst_q) |=> rst_irq);
  a_r3_irq_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (rst_irq && !irq_clr) |=> rst_irq);
endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;
  localparam int M_CFG = 0, M_JOIN = 1, M_IDLE = 2, M_TX = 3, M_RX = 4;

  logic       clk, rst_n, swrst_we, swrst_wdata, irq_clr, rx_bit, bit_stb;
  logic [3:0] tx_pend;
  logic       arb_lost, frame_done;
  logic       cfg_status, rst_irq, tx_start;
  logic [2:0] mode;
  int         n_run, n_fail, cyc;

  can_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .swrst_we(swrst_we), .swrst_wdata(swrst_wdata),
    .irq_clr(irq_clr), .rx_bit(rx_bit), .bit_stb(bit_stb), .tx_pend(tx_pend),
    .arb_lost(arb_lost), .frame_done(frame_done), .cfg_status(cfg_status),
    .rst_irq(rst_irq), .mode(mode), .tx_start(tx_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (act %0d, exp < 100000)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b; bit_stb = 1'b1;
    step();
    bit_stb = 1'b0; rx_bit = ~b;   // unstrobed opposite level must be ignored
    step();
    rx_bit = 1'b1;
  endtask

  task automatic wr_swrst(input logic v);
    swrst_we = 1'b1; swrst_wdata = v;
    step();
    swrst_we = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
  endtask

  task automatic finish_frame();
    frame_done = 1'b1; step(); frame_done = 1'b0;
  endtask

  // full join: 11 recessive bits then 25-cycle settle
  task automatic do_join();
    for (int i = 0; i < 11; i++) send_bit(1'b1);
    for (int i = 0; i < 24; i++) step();
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; swrst_we = 1'b0; swrst_wdata = 1'b0; irq_clr = 1'b0;
    rx_bit = 1'b1; bit_stb = 1'b0; tx_pend = '0; arb_lost = 1'b0; frame_done = 1'b0;
    step(); step(); step();
    chk("R1 mode in reset", mode, M_CFG);
    chk("R1 status in reset", cfg_status, 1);
    chk("R1 irq in reset", rst_irq, 1);
    rst_n = 1'b1;
    step(); step(); step();
    chk("R1 mode after reset", mode, M_CFG);
    chk("R1 status after reset", cfg_status, 1);
    chk("R1 irq after reset", rst_irq, 1);
    chk("R1 start low", tx_start, 0);
    chk("R10 cfg code", mode, 0);

    pulse_clr();
    chk("R3 irq cleared", rst_irq, 0);
    step();
    chk("R3 irq stays clear", rst_irq, 0);
    chk("R2 stays cfg", mode, M_CFG);

    // R4/R5 sweep: dominant bit after p recessive bits
    for (int p = 0; p <= 10; p++) begin
      wr_swrst(1'b1);
      chk("R2 cfg entry", mode, M_CFG);
      if (p > 0) chk("R2 irq set on entry", rst_irq, 1);
      pulse_clr();
      wr_swrst(1'b0);
      chk("R4 join mode", mode, M_JOIN);
      chk("R10 join code", mode, 1);
      for (int i = 0; i < p; i++) send_bit(1'b1);
      send_bit(1'b0);
      chk("R4 still joining after dominant", mode, M_JOIN);
      for (int i = 0; i < 10; i++) send_bit(1'b1);
      chk("R4 count restarted", mode, M_JOIN);
      chk("R4 status held", cfg_status, 1);
      send_bit(1'b1);
      for (int i = 0; i < 23; i++) step();
      chk("R5 one cycle before settle", mode, M_JOIN);
      chk("R5 status before settle", cfg_status, 1);
      step();
      chk("R5 idle after settle", mode, M_IDLE);
      chk("R5 status cleared", cfg_status, 0);
    end

    // R6 sweep over all pending vectors
    for (int v = 0; v < 16; v++) begin
      tx_pend = 4'(v);
      step();
      if (v == 0) begin
        chk("R6 idle with no request", mode, M_IDLE);
        chk("R6 no start", tx_start, 0);
      end else begin
        chk("R6 transmit", mode, M_TX);
        chk("R10 tx code", mode, 3);
        chk("R6 start pulse", tx_start, 1);
        step();
        chk("R6 start one cycle", tx_start, 0);
        chk("R6 stays transmitting", mode, M_TX);
        tx_pend = '0;
        finish_frame();
        chk("R9 tx frame done", mode, M_IDLE);
      end
    end

    // R7 reception start
    rx_bit = 1'b0; step(); rx_bit = 1'b1;
    chk("R7 unstrobed dominant ignored", mode, M_IDLE);
    send_bit(1'b0);
    chk("R7 receive", mode, M_RX);
    chk("R10 rx code", mode, 4);
    tx_pend = 4'b0100;
    step();
    chk("R9 rx holds while pending", mode, M_RX);
    finish_frame();
    chk("R9 rx frame done", mode, M_IDLE);
    step();
    chk("R9 pending rechecked", mode, M_TX);
    chk("R9 start after recheck", tx_start, 1);

    // R8 arbitration loss, with frame done at the same time
    arb_lost = 1'b1; frame_done = 1'b1; step(); arb_lost = 1'b0; frame_done = 1'b0;
    tx_pend = '0;
    chk("R8 arb loss to receive", mode, M_RX);
    chk("R8 no start", tx_start, 0);
    finish_frame();
    chk("R9 back to idle", mode, M_IDLE);
    // R6 priority over reception start
    tx_pend = 4'b0001; rx_bit = 1'b0; bit_stb = 1'b1; step();
    bit_stb = 1'b0; rx_bit = 1'b1;
    chk("R6 pending beats reception", mode, M_TX);

    // R2 soft reset from transmitting
    wr_swrst(1'b1);
    chk("R2 cfg from tx", mode, M_CFG);
    chk("R2 status set", cfg_status, 1);
    chk("R2 irq set", rst_irq, 1);
    tx_pend = '0;
    pulse_clr();
    wr_swrst(1'b1);
    chk("R2 no irq when already set", rst_irq, 0);
    // R3 set beats clear
    wr_swrst(1'b0);
    swrst_we = 1'b1; swrst_wdata = 1'b1; irq_clr = 1'b1;
    step();
    swrst_we = 1'b0; irq_clr = 1'b0;
    chk("R3 set wins over clear", rst_irq, 1);
    // R2 soft reset during settle window
    pulse_clr();
    wr_swrst(1'b0);
    for (int i = 0; i < 11; i++) send_bit(1'b1);
    for (int i = 0; i < 5; i++) step();
    wr_swrst(1'b1);
    chk("R2 cfg during settle", mode, M_CFG);
    wr_swrst(1'b0);
    do_join();
    chk("R5 rejoin after abort", mode, M_IDLE);
    send_bit(1'b0);
    wr_swrst(1'b1);
    chk("R2 cfg from rx", mode, M_CFG);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule